// File: doc/BRIEF.md
# NAND Flash Page Operation Sequencer

This block runs whole page-level operations on an asynchronous 16-bit NAND flash bus. A single start request, with an operation code, a block index and a page index, makes it perform a page read, a page program or a block erase. It forms the device byte address and emits the command and address latch cycles in the required order. Page data moves between the flash and a local word buffer through a simple address/data port. Ready is detected by polling the status register, with a bounded number of attempts.

Each strobe has a fixed shape. The write or read strobe is held low for a set number of clocks and then high for a set number of clocks. Program data words are spaced by an extra settle gap. When an operation ends, the block pulses a done flag for one cycle, together with a result code. Error correction and bad-block management are left to other logic.

Top module: `nand_page_seq`

## Requirements
- R1: In reset and while idle, busy and done are low, both strobes are high, both latch enables are low, and the data bus is not driven.
- R2: The byte address is (block << 17) + (page << 11). A page operation sends it in five address cycles, in this order: bits [7:0], bits [10:8], bits [18:11], bits [26:19], then bit 27. Unused high bits of each cycle are zero.
- R3: A read (op code 0) runs this sequence: command 0x00, five address cycles, command 0x30, status polling, command 0x00 again. It then reads MAIN_WORDS + SPARE_WORDS words. Word k is written to buffer address k.
- R4: A program (op code 1) runs this sequence: command 0x80, five address cycles, then the words from buffer addresses 0 to MAIN_WORDS + SPARE_WORDS − 1 in order (buffer read data is taken combinationally at the current buffer address). Then come command 0x10 and status polling.
- R5: An erase (op code 2) sends command 0x60, then three row cycles taken from the byte address shifted right by 11 (low byte first), then command 0xD0 and status polling.
- R6: One status poll is command 0x70 followed by a single data read. Bit 6 set means ready. Polling repeats until ready is seen.
- R7: If MAX_RETRY status reads in a row show not-ready, the operation ends with result timeout (2).
- R8: After ready, a program or erase ends with result fail (1) if status bit 0 is set, and ok (0) if it is clear. A read ignores bit 0 and ends ok.
- R9: Each operation ends with exactly one done pulse that lasts one cycle. The result code is ok = 0, fail = 1 or timeout = 2; the value 3 never appears.
- R10: A start request made while busy, or one carrying the reserved op code 3, is ignored. It causes no bus cycles and does not change the operation in progress.
- R11: Every write or read strobe stays low for exactly STB_LO clocks. The two strobes are never low together, and the command and address latch enables are never high together.
- R12: In a program, the rising edges of successive data write strobes are STB_LO + STB_HI + 1 + SETTLE_CYC clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| op_i | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| block_i | input | BLK_W | Block index |
| page_i | input | PG_W | Page index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Result code, valid with done_o |
| buf_addr_o | output | BUF_AW | Buffer word address |
| buf_we_o | output | 1 | Buffer write strobe (read data) |
| buf_wdata_o | output | 16 | Word read from flash |
| buf_rdata_i | input | 16 | Word to program, combinational from buf_addr_o |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 16 | Bus data out |
| nand_dq_oe_o | output | 1 | Bus output enable |
| nand_dq_i | input | 16 | Bus data in |

## Verification
The hardest cases to reach are the edges of the poll budget: ready arriving on the very last allowed status read, or never arriving at all. A read whose ready status also carries the fail bit is hard to reach for the same reason. The bench's flash model therefore counts busy polls per operation from a configured number, and returns a busy status word that has bit 0 set, so that a design reading the wrong bit is exposed. A second start request is injected while a program is running, and it has to leave the recorded bus trace unchanged. Address cycles are swept over walking-one block indices to cover every address bit split.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_FAIL    = 2'd1,
    RES_TIMEOUT = 2'd2
  } res_e;

  typedef enum logic [1:0] {
    BUS_CMD,
    BUS_ADR,
    BUS_WR,
    BUS_RD
  } bus_e;

  localparam logic [7:0] CMD_RD_SETUP  = 8'h00;
  localparam logic [7:0] CMD_RD_GO     = 8'h30;
  localparam logic [7:0] CMD_PG_SETUP  = 8'h80;
  localparam logic [7:0] CMD_PG_GO     = 8'h10;
  localparam logic [7:0] CMD_ER_SETUP  = 8'h60;
  localparam logic [7:0] CMD_ER_GO     = 8'h D0;
  localparam logic [7:0] CMD_STATUS    = 8'h70;

  localparam int STAT_RDY_BIT  = 6;
  localparam int STAT_FAIL_BIT = 0;

  function automatic logic [7:0] setup_cmd(op_e op);
    case (op)
      OP_PROG:  return CMD_PG_SETUP;
      OP_ERASE: return CMD_ER_SETUP;
      default:  return CMD_RD_SETUP;
    endcase
  endfunction

  function automatic logic [7:0] go_cmd(op_e op);
    case (op)
      OP_PROG:  return CMD_PG_GO;
      OP_ERASE: return CMD_ER_GO;
      default:  return CMD_RD_GO;
    endcase
  endfunction

endpackage

// File: rtl/nand_addr_gen.sv
module nand_addr_gen #(
  parameter int BLK_W       = 11,
  parameter int PG_W        = 6,
  parameter int BLOCK_SHIFT = 17,
  parameter int PAGE_SHIFT  = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BLK_W-1:0] block_i,
  input  logic [PG_W-1:0]  page_i,
  input  logic [2:0]       idx_i,
  input  logic             erase_i,
  output logic [7:0]       cyc_o,
  output logic             last_o
);
  localparam int AW = BLOCK_SHIFT + BLK_W;
  // row cycles of an erase reach bit 34
  localparam int XW = (AW > 35) ? AW : 35;

  logic [XW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (load_i)
      addr_q <= (XW'(block_i) << BLOCK_SHIFT) + (XW'(page_i) << PAGE_SHIFT);
  end

  always_comb begin
    if (erase_i) begin
      case (idx_i)
        3'd0:    cyc_o = addr_q[18:11];
        3'd1:    cyc_o = addr_q[26:19];
        default: cyc_o = addr_q[34:27];
      endcase
    end else begin
      case (idx_i)
        3'd0:    cyc_o = addr_q[7:0];
        3'd1:    cyc_o = {5'b0, addr_q[10:8]};
        3'd2:    cyc_o = addr_q[18:11];
        3'd3:    cyc_o = addr_q[26:19];
        default: cyc_o = {7'b0, addr_q[27]};
      endcase
    end
  end

  assign last_o = erase_i ? (idx_i == 3'd2) : (idx_i == 3'd4);

endmodule

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_seq_pkg::*;
#(
  parameter int STB_LO = 2,
  parameter int STB_HI = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  bus_e        kind_i,
  input  logic [15:0] data_i,
  output logic        ack_o,
  output logic [15:0] rdata_o,
  output logic        cle_o,
  output logic        ale_o,
  output logic        we_no,
  output logic        re_no,
  output logic [15:0] dq_o,
  output logic        dq_oe_o,
  input  logic [15:0] dq_i
);
  localparam int MAXC = (STB_LO > STB_HI) ? STB_LO : STB_HI;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  typedef enum logic [1:0] {BC_IDLE, BC_LOW, BC_HIGH} bc_e;

  bc_e         st_q;
  logic [CW-1:0] cnt_q;
  bus_e        kind_q;
  logic [15:0] data_q;
  logic [15:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BC_IDLE;
      cnt_q   <= '0;
      kind_q  <= BUS_CMD;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        BC_IDLE: if (req_i) begin
          st_q   <= BC_LOW;
          cnt_q  <= CW'(STB_LO - 1);
          kind_q <= kind_i;
          data_q <= data_i;
        end
        BC_LOW: if (cnt_q == '0) begin
          st_q  <= BC_HIGH;
          cnt_q <= CW'(STB_HI - 1);
          if (kind_q == BUS_RD) rdata_q <= dq_i;  // sample at strobe rise
        end else cnt_q <= cnt_q - 1'b1;
        BC_HIGH: if (cnt_q == '0) st_q <= BC_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: st_q <= BC_IDLE;
      endcase
    end
  end

  logic active;
  assign active  = (st_q != BC_IDLE);
  assign ack_o   = (st_q == BC_HIGH) && (cnt_q == '0);
  assign rdata_o = rdata_q;
  assign cle_o   = active && (kind_q == BUS_CMD);
  assign ale_o   = active && (kind_q == BUS_ADR);
  assign we_no   = !((st_q == BC_LOW) && (kind_q != BUS_RD));
  assign re_no   = !((st_q == BC_LOW) && (kind_q == BUS_RD));
  assign dq_o    = data_q;
  assign dq_oe_o = active && (kind_q != BUS_RD);

endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
  import nand_seq_pkg::*;
#(
  parameter int BLK_W       = 11,
  parameter int PG_W        = 6,
  parameter int BLOCK_SHIFT = 17,
  parameter int PAGE_SHIFT  = 11,
  parameter int MAIN_WORDS  = 1024,
  parameter int SPARE_WORDS = 32,
  parameter int MAX_RETRY   = 4096,
  parameter int STB_LO      = 2,
  parameter int STB_HI      = 2,
  parameter int SETTLE_CYC  = 4,
  localparam int TOTAL      = MAIN_WORDS + SPARE_WORDS,
  localparam int BUF_AW     = $clog2(TOTAL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [BLK_W-1:0]  block_i,
  input  logic [PG_W-1:0]   page_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic              buf_we_o,
  output logic [15:0]       buf_wdata_o,
  input  logic [15:0]       buf_rdata_i,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [15:0]       nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [15:0]       nand_dq_i
);
  localparam int WORD_W = $clog2(TOTAL + 1);
  localparam int RW     = (MAX_RETRY > 1) ? $clog2(MAX_RETRY) : 1;
  localparam int SW     = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADR, S_DAT, S_SETTLE, S_CONF,
    S_STCMD, S_STRD, S_RECMD, S_DONE
  } seq_e;

  seq_e              state_q;
  op_e               op_q;
  res_e              res_q;
  logic [2:0]        idx_q;
  logic [WORD_W-1:0] word_q;
  logic [RW-1:0]     retry_q;
  logic [SW-1:0]     settle_q;

  logic        accept;
  logic        bus_req, bus_ack;
  bus_e        bus_kind;
  logic [15:0] bus_data, bus_rdata;
  logic [7:0]  ag_cyc;
  logic        ag_last;

  assign accept = (state_q == S_IDLE) && start_i && (op_i != 2'b11);

  nand_addr_gen #(
    .BLK_W(BLK_W), .PG_W(PG_W),
    .BLOCK_SHIFT(BLOCK_SHIFT), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .block_i (block_i),
    .page_i  (page_i),
    .idx_i   (idx_q),
    .erase_i (op_q == OP_ERASE),
    .cyc_o   (ag_cyc),
    .last_o  (ag_last)
  );

  nand_bus_cycle #(.STB_LO(STB_LO), .STB_HI(STB_HI)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (bus_req),
    .kind_i  (bus_kind),
    .data_i  (bus_data),
    .ack_o   (bus_ack),
    .rdata_o (bus_rdata),
    .cle_o   (nand_cle_o),
    .ale_o   (nand_ale_o),
    .we_no   (nand_we_no),
    .re_no   (nand_re_no),
    .dq_o    (nand_dq_o),
    .dq_oe_o (nand_dq_oe_o),
    .dq_i    (nand_dq_i)
  );

  always_comb begin
    bus_req  = 1'b0;
    bus_kind = BUS_CMD;
    bus_data = '0;
    case (state_q)
      S_CMD:   begin bus_req = 1'b1; bus_data = {8'h00, setup_cmd(op_q)}; end
      S_ADR:   begin bus_req = 1'b1; bus_kind = BUS_ADR; bus_data = {8'h00, ag_cyc}; end
      S_DAT:   begin
        bus_req  = 1'b1;
        bus_kind = (op_q == OP_PROG) ? BUS_WR : BUS_RD;
        bus_data = buf_rdata_i;
      end
      S_CONF:  begin bus_req = 1'b1; bus_data = {8'h00, go_cmd(op_q)}; end
      S_STCMD: begin bus_req = 1'b1; bus_data = {8'h00, CMD_STATUS}; end
      S_STRD:  begin bus_req = 1'b1; bus_kind = BUS_RD; end
      S_RECMD: begin bus_req = 1'b1; bus_data = {8'h00, CMD_RD_SETUP}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= OP_READ;
      res_q    <= RES_OK;
      idx_q    <= '0;
      word_q   <= '0;
      retry_q  <= '0;
      settle_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          op_q    <= op_e'(op_i);
          idx_q   <= '0;
          word_q  <= '0;
          retry_q <= '0;
          state_q <= S_CMD;
        end
        S_CMD: if (bus_ack) state_q <= S_ADR;
        S_ADR: if (bus_ack) begin
          if (ag_last) state_q <= (op_q == OP_PROG) ? S_DAT : S_CONF;
          else idx_q <= idx_q + 3'd1;
        end
        S_DAT: if (bus_ack) begin
          word_q <= word_q + 1'b1;
          if (op_q == OP_PROG && SETTLE_CYC > 0) begin
            settle_q <= SW'(SETTLE_CYC - 1);
            state_q  <= S_SETTLE;
          end else if (word_q == WORD_W'(TOTAL - 1)) begin
            if (op_q == OP_PROG) state_q <= S_CONF;
            else begin
              res_q   <= RES_OK;
              state_q <= S_DONE;
            end
          end
        end
        S_SETTLE: begin
          if (settle_q == '0)
            state_q <= (word_q == WORD_W'(TOTAL)) ? S_CONF : S_DAT;
          else settle_q <= settle_q - 1'b1;
        end
        S_CONF:  if (bus_ack) state_q <= S_STCMD;
        S_STCMD: if (bus_ack) state_q <= S_STRD;
        S_STRD: if (bus_ack) begin
          if (bus_rdata[STAT_RDY_BIT]) begin
            if (op_q == OP_READ) state_q <= S_RECMD;
            else begin
              res_q   <= bus_rdata[STAT_FAIL_BIT] ? RES_FAIL : RES_OK;
              state_q <= S_DONE;
            end
          end else if (retry_q == RW'(MAX_RETRY - 1)) begin
            res_q   <= RES_TIMEOUT;
            state_q <= S_DONE;
          end else begin
            retry_q <= retry_q + 1'b1;
            state_q <= S_STCMD;
          end
        end
        S_RECMD: if (bus_ack) state_q <= S_DAT;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign result_o    = res_q;
  assign buf_addr_o  = word_q[BUF_AW-1:0];
  assign buf_we_o    = (state_q == S_DAT) && (op_q == OP_READ) && bus_ack;
  assign buf_wdata_o = bus_rdata;

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] result_o,
  input logic       nand_cle_o,
  input logic       nand_ale_o,
  input logic       nand_we_no,
  input logic       nand_re_no,
  input logic       nand_dq_oe_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (nand_we_no && nand_re_no && !nand_dq_oe_o && !nand_cle_o && !nand_ale_o));

  p_read_undriven_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o != 2'b11));

  p_busy_until_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> nand_re_no);

  p_latch_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_cle_o |-> !nand_ale_o);
endmodule

bind nand_page_seq nand_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .result_o     (result_o),
  .nand_cle_o   (nand_cle_o),
  .nand_ale_o   (nand_ale_o),
  .nand_we_no   (nand_we_no),
  .nand_re_no   (nand_re_no),
  .nand_dq_oe_o (nand_dq_oe_o)
);

// File: tb/tb_nand_page_seq.sv
module tb_nand_page_seq;
  localparam int MAINW = 8;
  localparam int SPAREW = 2;
  localparam int TOT = MAINW + SPAREW;
  localparam int MAXR = 4;
  localparam int LO = 2;
  localparam int HI = 1;
  localparam int SETL = 2;
  localparam int AWB = $clog2(TOT);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic            start_i = 1'b0;
  logic [1:0]      op_i = 2'd0;
  logic [10:0]     block_i = '0;
  logic [5:0]      page_i = '0;
  logic            busy_o, done_o;
  logic [1:0]      result_o;
  logic [AWB-1:0]  buf_addr_o;
  logic            buf_we_o;
  logic [15:0]     buf_wdata_o, buf_rdata_i;
  logic            nand_cle_o, nand_ale_o, nand_we_no, nand_re_no, nand_dq_oe_o;
  logic [15:0]     nand_dq_o, nand_dq_i;

  nand_page_seq #(
    .MAIN_WORDS(MAINW), .SPARE_WORDS(SPAREW), .MAX_RETRY(MAXR),
    .STB_LO(LO), .STB_HI(HI), .SETTLE_CYC(SETL)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .block_i(block_i), .page_i(page_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .buf_addr_o(buf_addr_o), .buf_we_o(buf_we_o),
    .buf_wdata_o(buf_wdata_o), .buf_rdata_i(buf_rdata_i),
    .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o), .nand_we_no(nand_we_no),
    .nand_re_no(nand_re_no), .nand_dq_o(nand_dq_o), .nand_dq_oe_o(nand_dq_oe_o),
    .nand_dq_i(nand_dq_i)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model and monitor state (driven only by the negedge monitor)
  logic [1:0]  ev_k [0:4095];
  logic [15:0] ev_v [0:4095];
  int          ev_n = 0;
  bit          st_mode = 1'b0;
  int          busy_left = 0;
  int          rd_ptr = 0;
  int          done_cnt = 0;
  logic [1:0]  res_seen = '0;
  logic        prev_we = 1'b1, prev_re = 1'b1, prev_done = 1'b0;
  int          lo_we = 0, lo_re = 0;
  int          cyc = 0, last_wr = -100, mon_op = 0;
  logic [15:0] bufm [0:TOT-1];

  // configuration (driven only by the stimulus)
  int          busy_cfg = 0;
  logic [15:0] fail_cfg = '0;
  logic [15:0] seed = '0;
  int          op_id = 0;

  function automatic logic [15:0] dev_word(int k);
    return 16'h5A00 ^ 16'(k * 16'h0133) ^ seed;
  endfunction

  function automatic logic [15:0] buf_word(int k);
    return 16'hC300 ^ 16'(k * 16'h0011) ^ seed;
  endfunction

  assign nand_dq_i   = st_mode ? ((busy_left > 0) ? 16'h0001 : (16'h00E0 | fail_cfg))
                               : dev_word(rd_ptr);
  assign buf_rdata_i = buf_word(int'(buf_addr_o));

  task automatic push_ev(input logic [1:0] k, input logic [15:0] v);
    if (ev_n < 4096) begin
      ev_k[ev_n] = k;
      ev_v[ev_n] = v;
      ev_n++;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_op != op_id) begin
      mon_op  = op_id;
      last_wr = -100;
    end
    if (buf_we_o) bufm[buf_addr_o] = buf_wdata_o;
    if (done_o) begin
      chk(!prev_done, "R9 done width", 64'(prev_done), 0);
      done_cnt++;
      res_seen = result_o;
    end
    if (!nand_we_no) lo_we++;
    else if (!prev_we) begin
      chk(lo_we == LO, "R11 write strobe low", lo_we, LO);
      lo_we = 0;
      if (nand_cle_o) begin
        push_ev(2'd0, {8'h00, nand_dq_o[7:0]});
        st_mode = (nand_dq_o[7:0] == 8'h70);
        if (nand_dq_o[7:0] == 8'h30 || nand_dq_o[7:0] == 8'h10 || nand_dq_o[7:0] == 8'hD0)
          busy_left = busy_cfg;
        if (nand_dq_o[7:0] == 8'h00) rd_ptr = 0;
      end else if (nand_ale_o) begin
        push_ev(2'd1, {8'h00, nand_dq_o[7:0]});
      end else begin
        push_ev(2'd2, nand_dq_o);
        if (last_wr >= 0)
          chk(cyc - last_wr == LO + HI + 1 + SETL, "R12 word spacing", cyc - last_wr, LO + HI + 1 + SETL);
        last_wr = cyc;
      end
    end
    if (!nand_re_no) lo_re++;
    else if (!prev_re) begin
      chk(lo_re == LO, "R11 read strobe low", lo_re, LO);
      lo_re = 0;
      push_ev(2'd3, nand_dq_i);
      if (st_mode) begin
        if (busy_left > 0) busy_left--;
      end else rd_ptr++;
    end
    prev_we   = nand_we_no;
    prev_re   = nand_re_no;
    prev_done = done_o;
  end

  // expected trace
  logic [1:0]  ex_k [0:255];
  logic [15:0] ex_v [0:255];
  int          ex_n = 0;

  task automatic ex_push(input logic [1:0] k, input logic [15:0] v);
    ex_k[ex_n] = k;
    ex_v[ex_n] = v;
    ex_n++;
  endtask

  task automatic ex_polls(input int busy, input bit fail, input bit check_fail, output int res);
    int n;
    n = (busy < MAXR) ? busy + 1 : MAXR;
    for (int j = 0; j < n; j++) begin
      ex_push(2'd0, 16'h0070);
      ex_push(2'd3, (j < busy) ? 16'h0001 : (16'h00E0 | 16'(fail)));
    end
    if (busy >= MAXR) res = 2;
    else if (check_fail && fail) res = 1;
    else res = 0;
  endtask

  task automatic run_op(input int op, input int blk, input int pg, input int busy,
                        input bit fail, input logic [15:0] sd, input bit poke);
    longint a, r;
    int base, d0, eres;
    string tag;
    tag = (op == 0) ? "R3" : (op == 1) ? "R4" : "R5";
    op_id++;
    seed = sd;
    busy_cfg = busy;
    fail_cfg = 16'(fail);
    base = ev_n;
    d0 = done_cnt;
    ex_n = 0;
    a = (longint'(blk) << 17) + (longint'(pg) << 11);
    r = a >> 11;
    if (op == 2) begin
      ex_push(2'd0, 16'h0060);
      ex_push(2'd1, 16'(r & 8'hFF));
      ex_push(2'd1, 16'((r >> 8) & 8'hFF));
      ex_push(2'd1, 16'((r >> 16) & 8'hFF));
      ex_push(2'd0, 16'h00D0);
      ex_polls(busy, fail, 1'b1, eres);
    end else begin
      ex_push(2'd0, (op == 0) ? 16'h0000 : 16'h0080);
      ex_push(2'd1, 16'(a & 8'hFF));
      ex_push(2'd1, 16'((a >> 8) & 3'h7));
      ex_push(2'd1, 16'((a >> 11) & 8'hFF));
      ex_push(2'd1, 16'((a >> 19) & 8'hFF));
      ex_push(2'd1, 16'((a >> 27) & 1));
      if (op == 0) begin
        ex_push(2'd0, 16'h0030);
        ex_polls(busy, fail, 1'b0, eres);
        if (eres == 0) begin
          ex_push(2'd0, 16'h0000);
          for (int k = 0; k < TOT; k++) ex_push(2'd3, dev_word(k));
        end
      end else begin
        for (int k = 0; k < TOT; k++) ex_push(2'd2, buf_word(k));
        ex_push(2'd0, 16'h0010);
        ex_polls(busy, fail, 1'b1, eres);
      end
    end
    @(negedge clk);
    start_i = 1'b1;
    op_i = 2'(op);
    block_i = 11'(blk);
    page_i = 6'(pg);
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      start_i = 1'b1;
      op_i = 2'd2;
      block_i = 11'd3;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int t = 0; t < 4000 && done_cnt == d0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt - d0 == 1, "R9 one done per op", done_cnt - d0, 1);
    chk(int'(res_seen) == eres, (eres == 2) ? "R7 result" : "R8 result", res_seen, eres);
    chk(ev_n - base == ex_n, {tag, " trace length"}, ev_n - base, ex_n);
    for (int i = 0; i < ex_n; i++)
      chk({ev_k[base+i], ev_v[base+i]} == {ex_k[i], ex_v[i]},
          (ex_k[i] == 2'd1) ? "R2 address cycle" : {tag, " R6 bus event"},
          {ev_k[base+i], ev_v[base+i]}, {ex_k[i], ex_v[i]});
    if (op == 0 && eres == 0)
      for (int k = 0; k < TOT; k++)
        chk(bufm[k] == dev_word(k), "R3 buffer word", bufm[k], dev_word(k));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o, "R1 busy/done in reset", {busy_o, done_o}, 0);
    chk(nand_we_no && nand_re_no, "R1 strobes in reset", {nand_we_no, nand_re_no}, 3);
    chk(!nand_cle_o && !nand_ale_o && !nand_dq_oe_o, "R1 latches in reset",
        {nand_cle_o, nand_ale_o, nand_dq_oe_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    run_op(0, 5, 3, 1, 1'b0, 16'h1111, 1'b0);       // R3 basic read
    run_op(0, 1029, 63, 0, 1'b1, 16'h2222, 1'b0);   // R8 read ignores fail bit
    run_op(1, 2047, 0, 2, 1'b0, 16'h3333, 1'b0);    // R4 R12
    run_op(1, 17, 33, 0, 1'b1, 16'h4444, 1'b0);     // R8 program fail
    run_op(2, 1500, 0, MAXR - 1, 1'b0, 16'h0, 1'b0); // R6 ready on last poll
    run_op(2, 2, 0, MAXR, 1'b0, 16'h0, 1'b0);       // R7 erase timeout
    run_op(2, 777, 9, 0, 1'b1, 16'h0, 1'b0);        // R8 erase fail
    run_op(0, 64, 1, MAXR + 5, 1'b0, 16'h5555, 1'b0); // R7 read timeout
    run_op(1, 300, 20, 1, 1'b0, 16'h6666, 1'b1);    // R10 start while busy

    // R10 reserved op code
    begin
      int base;
      bit seen_busy;
      base = ev_n;
      seen_busy = 1'b0;
      @(negedge clk);
      start_i = 1'b1;
      op_i = 2'd3;
      @(negedge clk);
      start_i = 1'b0;
      for (int t = 0; t < 12; t++) begin
        if (busy_o) seen_busy = 1'b1;
        @(negedge clk);
      end
      chk(!seen_busy, "R10 reserved op busy", seen_busy, 0);
      chk(ev_n == base, "R10 reserved op bus", ev_n - base, 0);
    end

    // R2 walking-one block sweep over reads and erases
    for (int i = 0; i < 11; i++) begin
      run_op(0, 1 << i, (i * 6) % 64, i % 3, 1'b0, 16'(i * 16'h0105), 1'b0);
      run_op(2, (1 << i) | 1, (i * 11) % 64, 0, 1'b0, 16'h0, 1'b0);
    end

    summary();
    $finish;
  end

endmodule